// File: doc/BRIEF.md
# Galois LFSR Random Bit Streamer

This block produces a pseudo-random bit stream from a linear feedback shift register arranged in the one-to-many form: the register's output stage is fed back into every tapped stage, so each stage sees at most one XOR gate between itself and its neighbour. The register width is a parameter. Two maximal configurations are supported: 5 bits with a period of 31 and 8 bits with a period of 255. Each random bit leaves through a valid/ready stream master. The register moves one step for each accepted beat and never moves otherwise.

Back-pressure rules: after reset `m_tvalid_o` stays high for as long as no seed load is requested. A beat is transferred on a rising clock edge where `m_tvalid_o` and `m_tready_i` are both high. While `m_tready_i` is low, both `m_tdata_o` and the register hold their values. A seed load is a plain control pin. While it is high, `m_tvalid_o` is forced low, so a load never coincides with a transfer.

The whole register is also brought out on `state_o`. A consumer can use it as a pseudo-random count sequence or as a divider, for example by acting on a subset such as the first 16 states of the 31-state sequence.

Top module: `galstream_lfsr`

## Requirements
- R1: While `rst_i` is high, `m_tvalid_o` is low and the register is loaded with parameter `SEED` (default 1). From the first rising edge with reset low, `m_tvalid_o` is high whenever `seed_load_i` is low.
- R2: The register and `m_tdata_o` change only on a cycle where `m_tvalid_o` and `m_tready_i` are both high, or on a seed load. With `m_tready_i` low, both hold their values.
- R3: One step, with o = state[0]: state'[WIDTH-1] = o, and for every i < WIDTH-1, state'[i] = state[i+1] XOR (o AND tap[i]). Untapped stages shift unchanged. The 8-bit taps are at indices 1, 2, 3 and 7. The 5-bit taps are at indices 2 and 4, from x^5 + x^3 + 1.
- R4: The stream bit is `m_tdata_o[0]`, which equals `state_o[0]`. All other `m_tdata_o` bits are zero.
- R5: In the 8-bit configuration, starting from any nonzero state, the state returns to its start after exactly 255 transfers, and no value repeats before that.
- R6: `state_o` is never zero after reset.
- R7: A cycle with `seed_load_i` high loads `seed_value_i` into the register. If that value is zero, the constant 1 is loaded instead. `m_tvalid_o` is low during that cycle.
- R8: In the 5-bit configuration the state returns to its start after exactly 31 transfers, and its first 16 states after reset are all distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| seed_load_i | input | 1 | Load `seed_value_i` into the register |
| seed_value_i | input | WIDTH | Seed value to load |
| m_tready_i | input | 1 | Stream consumer ready |
| m_tvalid_o | output | 1 | Stream beat valid |
| m_tdata_o | output | DATA_W | Stream data; bit 0 carries the random bit |
| state_o | output | WIDTH | Full register state |

## Verification
Every result is due one rising edge after its cause. A transfer or a seed load at edge k shows up on `state_o` and `m_tdata_o` from edge k onward. `m_tvalid_o` follows `seed_load_i` within the same cycle and rises one edge after reset is released. The driver sets inputs on the falling edge. Just after the following rising edge it pushes the state a reference model predicts for that edge. The monitor pops and compares on the next falling edge, so each comparison falls exactly one register stage after its stimulus. The period checks count transfers as they happen: 255 for the 8-bit instance and 31 for a free-running 5-bit instance.

// File: rtl/galstream_pkg.sv
package galstream_pkg;

  // Feedback mask: bit i set means stage i receives the output bit.
  // The top stage always receives it.
  function automatic logic [31:0] feedback_mask(input int unsigned w);
    case (w)
      5:       return 32'h0000_0014;  // x^5 + x^3 + 1
      8:       return 32'h0000_008E;  // taps 1,2,3,7
      default: return 32'h1 << (w - 1);
    endcase
  endfunction

  // Value substituted when a zero seed is requested
  localparam int unsigned ZERO_FILL = 1;

endpackage

// File: rtl/galstream_next.sv
module galstream_next
  import galstream_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam logic [31:0]      MASK_FULL = feedback_mask(WIDTH);
  localparam logic [WIDTH-1:0] MASK      = MASK_FULL[WIDTH-1:0];

  logic fb;
  assign fb = cur_i[0];

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == WIDTH - 1) begin : g_top
      assign nxt_o[i] = fb;
    end else if (MASK[i]) begin : g_tap
      assign nxt_o[i] = cur_i[i+1] ^ fb;
    end else begin : g_plain
      assign nxt_o[i] = cur_i[i+1];
    end
  end

endmodule

// File: rtl/galstream_reg.sv
module galstream_reg
  import galstream_pkg::*;
#(
  parameter int unsigned          WIDTH = 8,
  parameter logic [WIDTH-1:0]     SEED  = 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] state_o
);
  localparam logic [WIDTH-1:0] FILL = WIDTH'(ZERO_FILL);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] load_eff;

  assign load_eff = (load_val_i == '0) ? FILL : load_val_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)       state_q <= SEED;
    else if (load_i) state_q <= load_eff;
    else if (step_i) state_q <= nxt_i;
  end

  assign state_o = state_q;

  AST_RESET_SEED: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> state_q == SEED); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!step_i && !load_i) |=> $stable(state_q)); // R2
  AST_TOP_FEED: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && !load_i) |=> state_q[WIDTH-1] == $past(state_q[0])); // R3
  AST_NEVER_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    state_q != '0); // R6
  AST_LOAD_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_i && load_val_i == '0) |=> state_q == FILL); // R7

endmodule

// File: rtl/galstream_src.sv
module galstream_src (
  input  logic clk_i,
  input  logic rst_i,
  input  logic load_i,
  input  logic ready_i,
  output logic valid_o,
  output logic step_o
);
  logic live_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) live_q <= 1'b0;
    else       live_q <= 1'b1;
  end

  assign valid_o = live_q & ~load_i;
  assign step_o  = valid_o & ready_i;

  AST_VALID_UP: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !load_i) |-> valid_o); // R1
  AST_LOAD_BLOCKS: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |-> !step_o); // R7

endmodule

// File: rtl/galstream_lfsr.sv
module galstream_lfsr
  import galstream_pkg::*;
#(
  parameter int unsigned      WIDTH  = 8,
  parameter int unsigned      DATA_W = 8,
  parameter logic [WIDTH-1:0] SEED   = 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              seed_load_i,
  input  logic [WIDTH-1:0]  seed_value_i,
  input  logic              m_tready_i,
  output logic              m_tvalid_o,
  output logic [DATA_W-1:0] m_tdata_o,
  output logic [WIDTH-1:0]  state_o
);
  logic             step;
  logic [WIDTH-1:0] cur;
  logic [WIDTH-1:0] nxt;

  galstream_src u_src (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .load_i  (seed_load_i),
    .ready_i (m_tready_i),
    .valid_o (m_tvalid_o),
    .step_o  (step)
  );

  galstream_next #(.WIDTH(WIDTH)) u_next (
    .cur_i (cur),
    .nxt_o (nxt)
  );

  galstream_reg #(.WIDTH(WIDTH), .SEED(SEED)) u_reg (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .step_i     (step),
    .load_i     (seed_load_i),
    .load_val_i (seed_value_i),
    .nxt_i      (nxt),
    .state_o    (cur)
  );

  assign state_o   = cur;
  assign m_tdata_o = {{(DATA_W-1){1'b0}}, cur[0]};

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (m_tvalid_o && !m_tready_i) |=> $stable(m_tdata_o)); // R2
  AST_DATA_UPPER: assert property (@(posedge clk_i) disable iff (rst_i)
    m_tdata_o[DATA_W-1:1] == '0); // R4

endmodule

// File: tb/galstream_lfsr_tb.sv
module galstream_lfsr_tb;
  localparam int W  = 8;
  localparam int DW = 8;
  localparam logic [W-1:0] MASK8 = 8'h8E;  // taps 1,2,3,7
  localparam logic [4:0]   MASK5 = 5'h14;  // taps 2,4

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld = 1'b0;
  logic [W-1:0] ldv = '0;
  logic rdy = 1'b0;
  logic vld;
  logic [DW-1:0] tdata;
  logic [W-1:0] st;

  logic vld5;
  logic [7:0] tdata5;
  logic [4:0] st5;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] exp_st;
  logic [W-1:0] exp_q[$];

  bit track = 0;
  logic [W-1:0] trk_start;
  int trk_n = 0;
  bit [255:0] seen;

  always #10 clk = ~clk;  // 50 MHz

  galstream_lfsr #(.WIDTH(W), .DATA_W(DW), .SEED(8'h01)) u_dut (
    .clk_i(clk), .rst_i(rst), .seed_load_i(ld), .seed_value_i(ldv),
    .m_tready_i(rdy), .m_tvalid_o(vld), .m_tdata_o(tdata), .state_o(st));

  galstream_lfsr #(.WIDTH(5), .DATA_W(8), .SEED(5'h01)) u_dut5 (
    .clk_i(clk), .rst_i(rst), .seed_load_i(1'b0), .seed_value_i(5'h00),
    .m_tready_i(1'b1), .m_tvalid_o(vld5), .m_tdata_o(tdata5), .state_o(st5));

  // Reference step from R3
  function automatic logic [W-1:0] step8(input logic [W-1:0] s);
    logic [W-1:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ MASK8;
    return n;
  endfunction

  function automatic logic [4:0] step5(input logic [4:0] s);
    logic [4:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ MASK5;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: sets inputs for one cycle and pushes the state expected after the edge
  task automatic drive(input logic r, input logic l, input logic [W-1:0] v);
    @(negedge clk);
    #1;
    if (track) begin
      if (trk_n == 255) begin
        check(st == trk_start, "R5 period 255", st, trk_start);
        track = 0;
      end else if (trk_n > 0) begin
        check(!seen[st], "R5 no repeat", st, 0);
        seen[st] = 1'b1;
      end
    end
    rdy = r; ld = l; ldv = v;
    #1;
    check(vld == !l, "R1/R7 tvalid", vld, !l);
    @(posedge clk);
    #1;
    if (l) exp_st = (v == '0) ? 8'h01 : v;
    else if (r) exp_st = step8(exp_st);
    if (track) trk_n++;
    exp_q.push_back(exp_st);
  endtask

  // Monitor: compares each produced state at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      e = exp_q.pop_front();
      check(st == e, "R2/R3/R7 state", st, e);
      check(tdata[0] == e[0], "R4 tdata bit", tdata[0], e[0]);
      check(tdata[DW-1:1] == '0, "R4 upper zero", tdata, e[0]);
      check(st != '0, "R6 nonzero", st, 1);
    end
  end

  // Free-running 5-bit instance: R8
  int n5 = 0;
  logic [4:0] s5_start;
  logic [4:0] s5_exp;
  bit [31:0] seen5;
  always @(negedge clk) begin
    if (!rst && vld5 && n5 <= 31) begin
      if (n5 == 0) begin
        s5_start = st5; s5_exp = st5; seen5 = '0; seen5[st5] = 1'b1;
        check(st5 == 5'h01, "R8 start", st5, 1);
      end else begin
        s5_exp = step5(s5_exp);
        check(st5 == s5_exp, "R8 step", st5, s5_exp);
        if (n5 < 31) begin
          check(!seen5[st5], "R8 no repeat", st5, 0);
          seen5[st5] = 1'b1;
        end else begin
          check(st5 == s5_start, "R8 period 31", st5, s5_start);
        end
      end
      n5++;
    end
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_st = 8'h01;
    repeat (3) @(negedge clk);
    check(vld == 1'b0, "R1 tvalid in reset", vld, 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(st == 8'h01, "R1 seed", st, 1);
    check(vld == 1'b1, "R1 tvalid up", vld, 1);
    // Stalls then steps, mixed ready pattern
    for (int k = 0; k < 20; k++) drive(k % 3 == 0, 1'b0, '0);
    for (int k = 0; k < 6; k++) drive(1'b0, 1'b0, '0);  // R2 hold
    // Seed loads: nonzero then zero (R7)
    drive(1'b1, 1'b1, 8'hC3);
    drive(1'b1, 1'b0, '0);
    drive(1'b0, 1'b1, 8'h00);
    drive(1'b0, 1'b0, '0);
    drive(1'b1, 1'b0, '0);
    // Full period from 8'h5A (R5)
    drive(1'b0, 1'b1, 8'h5A);
    @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    rdy = 1'b0; ld = 1'b0;
    trk_start = 8'h5A; seen = '0; seen[8'h5A] = 1'b1; trk_n = 0; track = 1;
    for (int k = 0; k < 256; k++) drive(1'b1, 1'b0, '0);
    check(track == 0, "R5 period reached", track, 0);
    drive(1'b0, 1'b0, '0);
    repeat (3) @(negedge clk);
    check(n5 > 31, "R8 run length", n5, 32);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule